// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel with its own bit-rate timer. A host reaches it through a small register port with four addresses. Address 0 is the data address: a write lands in the transmit holding buffer and a read returns the receive holding buffer. Address 1 holds the mode, address 2 holds the rate divisor and address 3 returns status. Characters are 7, 8 or 9 bits long. Parity is optional and can be even or odd. There are one or two stop bits. A clock divider with four settings feeds an (n+1) counter that produces a 16x sampling tick.

Each direction has a holding buffer ahead of its shift register. The host can queue the next character while one is still shifting out. A received character waits in its buffer while the next one arrives. Two level-sensitive interrupt requests are provided. The receive request follows the receive-full flag. The transmit request follows either buffer-empty or transmission-complete, as set by a mode bit. With the flow-control option built in, the channel waits for clear-to-send before it starts a character. It also drives ready-to-send from its receive buffer state.

Mode register fields: bits [1:0] set the length (0 gives 7 bits, 1 gives 8 bits, 2 or 3 give 9 bits). Bit 2 enables parity and bit 3 selects odd parity. Bit 4 selects two stop bits. Bits [6:5] pick the clock divide (0 is /1, 1 is /8, 2 is /32, 3 is /256). Bit 7 sets the transmit interrupt source (0 is buffer-empty, 1 is complete). Bit 8 enables clear-to-send gating. The mode register resets to 8-bit, no parity, one stop bit, /1 and buffer-empty source. The divisor resets to 0.

Top module: `uart_chan`

## Requirements
- R1: After reset, status reads 0x003: bit 0 transmit-buffer-empty is 1, bit 1 transmit-complete is 1, and bit 2 receive-full, bit 3 overrun, bit 4 parity error and bit 5 framing error are all 0. Also txd=1, rts_n=0, tx_irq=1 and rx_irq=0.
- R2: Every serial bit lasts D*(n+1)*16 clock cycles. D is 1, 8, 32 or 256 for divide codes 0..3 and n is the divisor register.
- R3: A transmitted frame is one low start bit, then the data bits LSB first (7, 8 or 9 by length code), then the parity bit if enabled, then one or two high stop bits.
- R4: The parity bit makes the count of ones over data plus parity even when bit 3 is 0, and odd when bit 3 is 1.
- R5: A data-address write clears buffer-empty. The buffer is set empty again once its character moves to the shift register, so a second character can be written while the first is still shifting.
- R6: Transmit-complete is 1 only when the buffer is empty and no frame is shifting. tx_irq equals buffer-empty when mode bit 7 is 0, and transmit-complete when it is 1.
- R7: A received character appears right-justified at the data address and sets receive-full and rx_irq. A data-address read clears receive-full.
- R8: A low pulse on rxd that ends before mid-bit is not taken as a start bit and produces no character.
- R9: A character that completes while receive-full is set sets overrun and leaves the buffered character unchanged. A data-address read clears overrun.
- R10: A parity mismatch sets status bit 4 and a low first stop bit sets status bit 5. Both describe the character in the buffer.
- R11: With mode bit 8 set, no frame starts while cts_n is high. A pending character starts once cts_n goes low.
- R12: rts_n is low while the receive buffer is empty and high while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register address (0 data, 1 mode, 2 divisor, 3 status) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; reading the data address has side effects |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for reg_addr, combinational |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Ready-to-send, active low |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume the following about the inputs. The host does not change the mode or divisor while a frame is in flight. cts_n is synchronous to clk. The data-address read strobe is a one-cycle pulse. The stimulus changes the mode only after transmit-complete reads back as 1 and the receive line has been idle for a bit time. It drives cts_n and rxd at falling clock edges, and it issues each register access as a single-cycle strobe. Received frames are driven at the exact bit period the mode implies, so the checks on the receive side test framing and flags rather than tolerance to rate error.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

   localparam int CHR_W = 9;

   typedef struct packed {
      logic       cts_en;
      logic       txi_sel;
      logic [1:0] psel;
      logic       stop2;
      logic       par_odd;
      logic       par_en;
      logic [1:0] len;
   } chan_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
   } frame_st_t;

   function automatic logic [3:0] char_bits(input logic [1:0] len);
      case (len)
         2'd0:    return 4'd7;
         2'd1:    return 4'd8;
         default: return 4'd9;
      endcase
   endfunction

   function automatic logic [CHR_W-1:0] char_mask(input logic [1:0] len);
      case (len)
         2'd0:    return 9'h07F;
         2'd1:    return 9'h0FF;
         default: return 9'h1FF;
      endcase
   endfunction

   function automatic logic par_bit(input logic [CHR_W-1:0] d,
                                    input logic [1:0] len,
                                    input logic odd);
      return (^(d & char_mask(len))) ^ odd;
   endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       psel,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   localparam int PRE_W = 8;

   logic [PRE_W-1:0] pre_cnt, pre_lim;
   logic [DIV_W-1:0] div_cnt;
   logic             fi_en;

   always_comb begin
      case (psel)
         2'd0:    pre_lim = 8'd0;
         2'd1:    pre_lim = 8'd7;
         2'd2:    pre_lim = 8'd31;
         default: pre_lim = 8'd255;
      endcase
   end

   assign fi_en = (pre_cnt >= pre_lim);
   assign tick  = fi_en && (div_cnt >= divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else begin
         pre_cnt <= fi_en ? '0 : pre_cnt + 1'b1;
         if (fi_en)
            div_cnt <= (div_cnt >= divisor) ? '0 : div_cnt + 1'b1;
      end
   end

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (psel != 2'd0 || divisor != '0)) |=> !tick)
      else $error("sampling ticks back to back with a divide above one");

endmodule

// File: rtl/uart_tx.sv
module uart_tx
   import uart_chan_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [CHR_W-1:0] data,
   input  logic [1:0]       len,
   input  logic             par_en,
   input  logic             par_odd,
   input  logic             stop2,
   output logic             txd,
   output logic             busy
);
   frame_st_t        st;
   logic [3:0]       tcnt, bidx;
   logic [CHR_W-1:0] shreg;
   logic             par, stop_more;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tcnt      <= '0;
         bidx      <= '0;
         shreg     <= '0;
         par       <= 1'b0;
         stop_more <= 1'b0;
      end else if (st == ST_IDLE) begin
         if (start) begin
            shreg     <= data & char_mask(len);
            par       <= par_bit(data, len, par_odd);
            stop_more <= stop2;
            tcnt      <= '0;
            bidx      <= '0;
            st        <= ST_START;
         end
      end else if (tick) begin
         if (tcnt == 4'd15) begin
            tcnt <= '0;
            case (st)
               ST_START: st <= ST_DATA;
               ST_DATA:
                  if (bidx == char_bits(len) - 4'd1)
                     st <= par_en ? ST_PAR : ST_STOP;
                  else
                     bidx <= bidx + 4'd1;
               ST_PAR:   st <= ST_STOP;
               ST_STOP:
                  if (stop_more) stop_more <= 1'b0;
                  else           st <= ST_IDLE;
               default:  st <= ST_IDLE;
            endcase
         end else begin
            tcnt <= tcnt + 4'd1;
         end
      end
   end

   always_comb begin
      case (st)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = shreg[bidx];
         ST_PAR:   txd = par;
         default:  txd = 1'b1;
      endcase
   end

   assign busy = (st != ST_IDLE);

   // R5
   start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start)
      else $error("buffer handed over while a frame is still shifting");

endmodule

// File: rtl/uart_rx.sv
module uart_rx
   import uart_chan_pkg::*;
#(
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rxd,
   input  logic [1:0]       len,
   input  logic             par_en,
   input  logic             par_odd,
   output logic             done,
   output logic [CHR_W-1:0] rdata,
   output logic             perr,
   output logic             ferr
);
   logic [SYNC_N-1:0] sync;
   logic              rxd_s, armed, rpar;
   frame_st_t         st;
   logic [3:0]        tcnt, bidx;

   generate
      if (SYNC_N == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync <= '1;
            else        sync <= rxd;
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync <= '1;
            else        sync <= {sync[SYNC_N-2:0], rxd};
      end
   endgenerate
   assign rxd_s = sync[SYNC_N-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         tcnt  <= '0;
         bidx  <= '0;
         rdata <= '0;
         rpar  <= 1'b0;
         armed <= 1'b0;
         done  <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               ST_IDLE: begin
                  armed <= rxd_s;
                  if (armed && !rxd_s) begin
                     st    <= ST_START;
                     tcnt  <= '0;
                     rdata <= '0;
                  end
               end
               ST_START:
                  if (tcnt == 4'd6) begin
                     tcnt <= '0;
                     bidx <= '0;
                     if (rxd_s) begin
                        st    <= ST_IDLE;
                        armed <= 1'b1;
                     end else begin
                        st <= ST_DATA;
                     end
                  end else begin
                     tcnt <= tcnt + 4'd1;
                  end
               default:
                  if (tcnt == 4'd15) begin
                     tcnt <= '0;
                     case (st)
                        ST_DATA: begin
                           rdata[bidx] <= rxd_s;
                           if (bidx == char_bits(len) - 4'd1)
                              st <= par_en ? ST_PAR : ST_STOP;
                           else
                              bidx <= bidx + 4'd1;
                        end
                        ST_PAR: begin
                           rpar <= rxd_s;
                           st   <= ST_STOP;
                        end
                        default: begin
                           done  <= 1'b1;
                           ferr  <= !rxd_s;
                           perr  <= par_en && (rpar != par_bit(rdata, len, par_odd));
                           armed <= rxd_s;
                           st    <= ST_IDLE;
                        end
                     endcase
                  end else begin
                     tcnt <= tcnt + 4'd1;
                  end
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_chan.sv
module uart_chan
   import uart_chan_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int SYNC_N   = 2,
   parameter bit HAS_FLOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [CHR_W-1:0] reg_wdata,
   output logic [CHR_W-1:0] reg_rdata,
   input  logic             rxd,
   input  logic             cts_n,
   output logic             txd,
   output logic             rts_n,
   output logic             tx_irq,
   output logic             rx_irq
);
   localparam logic [1:0] ADR_DATA = 2'd0;
   localparam logic [1:0] ADR_MODE = 2'd1;
   localparam logic [1:0] ADR_DIV  = 2'd2;
   localparam logic [1:0] ADR_STAT = 2'd3;

   if (DIV_W < 1 || DIV_W > CHR_W) begin : g_bad_div_w
      $error("DIV_W must lie between 1 and the register width");
   end
   if (SYNC_N < 1 || SYNC_N > 4) begin : g_bad_sync
      $error("SYNC_N must lie between 1 and 4");
   end

   logic [CHR_W-1:0] mode_q, tx_buf, rx_buf, rx_data;
   logic [DIV_W-1:0] div_q;
   chan_cfg_t        cfg;
   logic             tbe, tc, rbf, oe, pe, fe;
   logic             tick, tx_busy, tx_start, cts_ok;
   logic             rx_done, rx_perr, rx_ferr;
   logic             wr_data, rd_data;

   assign cfg     = chan_cfg_t'(mode_q);
   assign wr_data = reg_wr && reg_addr == ADR_DATA;
   assign rd_data = reg_rd && reg_addr == ADR_DATA;

   generate
      if (HAS_FLOW) begin : g_flow
         assign cts_ok = !cfg.cts_en || !cts_n;
         assign rts_n  = rbf;
      end else begin : g_noflow
         assign cts_ok = 1'b1;
         assign rts_n  = 1'b0;
      end
   endgenerate

   assign tx_start = !tbe && !tx_busy && cts_ok;
   assign tc       = tbe && !tx_busy;
   assign tx_irq   = cfg.txi_sel ? tc : tbe;
   assign rx_irq   = rbf;

   uart_baud #(.DIV_W(DIV_W)) baud_i (
      .clk(clk), .rst_n(rst_n), .psel(cfg.psel), .divisor(div_q), .tick(tick));

   uart_tx tx_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start), .data(tx_buf),
      .len(cfg.len), .par_en(cfg.par_en), .par_odd(cfg.par_odd), .stop2(cfg.stop2),
      .txd(txd), .busy(tx_busy));

   uart_rx #(.SYNC_N(SYNC_N)) rx_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .len(cfg.len), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
      .done(rx_done), .rdata(rx_data), .perr(rx_perr), .ferr(rx_ferr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 9'h001;
         div_q  <= '0;
         tx_buf <= '0;
         tbe    <= 1'b1;
      end else begin
         if (reg_wr && reg_addr == ADR_MODE) mode_q <= reg_wdata;
         if (reg_wr && reg_addr == ADR_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
         if (tx_start) tbe <= 1'b1;
         if (wr_data) begin
            tx_buf <= reg_wdata;
            tbe    <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf <= '0;
         rbf    <= 1'b0;
         oe     <= 1'b0;
         pe     <= 1'b0;
         fe     <= 1'b0;
      end else begin
         if (rd_data) begin
            rbf <= 1'b0;
            oe  <= 1'b0;
         end
         if (rx_done) begin
            if (rbf && !rd_data) begin
               oe <= 1'b1;
            end else begin
               rx_buf <= rx_data;
               rbf    <= 1'b1;
               pe     <= rx_perr;
               fe     <= rx_ferr;
            end
         end
      end
   end

   always_comb begin
      case (reg_addr)
         ADR_DATA: reg_rdata = rx_buf;
         ADR_MODE: reg_rdata = mode_q;
         ADR_DIV:  reg_rdata = CHR_W'(div_q);
         default:  reg_rdata = {3'b000, fe, pe, oe, rbf, tc, tbe};
      endcase
   end

   // R5
   tbe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> !tbe)
      else $error("buffer still empty after a data write");

   // R7
   rbf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rbf) |-> $past(rd_data))
      else $error("receive-full dropped without a data read");

   // R9
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> ($stable(rx_buf) && $past(rbf)))
      else $error("overrun disturbed the buffered character");

   // R11
   cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_busy) && HAS_FLOW && cfg.cts_en) |-> !$past(cts_n))
      else $error("frame started while clear-to-send was deasserted");

endmodule

// File: tb/uart_chan_tb_top.sv
`timescale 1ns/1ps
module uart_chan_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [8:0] reg_wdata = '0;
   logic [8:0] reg_rdata;
   logic       rxd = 1'b1, cts_n = 1'b0;
   logic       txd, rts_n, tx_irq, rx_irq;

   int tests = 0, fails = 0, cyc = 0, bitp = 64;
   bit finished = 1'b0;

   int m_nb = 8; bit m_pe = 0, m_odd = 0, m_s2 = 0;

   typedef struct { logic [8:0] d; int nb; bit pe; bit odd; bit s2; } txexp_t;
   txexp_t txq[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_chan dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .cts_n(cts_n),
      .txd(txd), .rts_n(rts_n), .tx_irq(tx_irq), .rx_irq(rx_irq));

   task automatic chk_eq(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic waitclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [8:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [8:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic configure(input int len, input bit pe, input bit odd, input bit s2,
                            input int psel, input bit txi, input bit cts, input int n);
      int dv;
      reg_write(2'd2, 9'(n));
      reg_write(2'd1, {cts, txi, 2'(psel), s2, odd, pe, 2'(len)});
      m_nb = (len == 0) ? 7 : (len == 1) ? 8 : 9;
      m_pe = pe; m_odd = odd; m_s2 = s2;
      dv = (psel == 0) ? 1 : (psel == 1) ? 8 : (psel == 2) ? 32 : 256;
      bitp = dv * (n + 1) * 16;
   endtask

   function automatic bit exp_par(input logic [8:0] d, input int nb, input bit odd);
      bit p = odd;
      for (int i = 0; i < nb; i++) p ^= d[i];
      return p;
   endfunction

   // driver: pushes the expected frame, then writes the data address
   task automatic send_tx(input logic [8:0] d);
      txexp_t e;
      e.d = d & 9'((1 << m_nb) - 1); e.nb = m_nb; e.pe = m_pe; e.odd = m_odd; e.s2 = m_s2;
      txq.push_back(e);
      reg_write(2'd0, d);
   endtask

   task automatic wait_tx_idle();
      logic [8:0] s;
      do begin
         waitclk(16);
         reg_read(2'd3, s);
      end while (!s[1] || txq.size() != 0);
      waitclk(4);
   endtask

   task automatic send_rx(input logic [8:0] d, input bit bad_par, input bit bad_stop);
      rxd = 1'b0; waitclk(bitp);
      for (int i = 0; i < m_nb; i++) begin rxd = d[i]; waitclk(bitp); end
      if (m_pe) begin rxd = exp_par(d, m_nb, m_odd) ^ bad_par; waitclk(bitp); end
      rxd = !bad_stop; waitclk(bitp);
      rxd = 1'b1; waitclk(bitp);
   endtask

   // monitor: decodes each frame on txd and compares with the queue head
   initial begin
      txexp_t e;
      logic [8:0] bits;
      logic st, pb, s1, s2;
      @(posedge rst_n);
      forever begin
         @(negedge txd);
         if (txq.size() == 0) begin
            chk_eq("R3 unexpected frame", 1, 0);
         end else begin
            e = txq.pop_front();
            waitclk(bitp / 2);
            st = txd; bits = '0; pb = 1'b0; s2 = 1'b1;
            for (int i = 0; i < e.nb; i++) begin waitclk(bitp); bits[i] = txd; end
            if (e.pe) begin waitclk(bitp); pb = txd; end
            waitclk(bitp); s1 = txd;
            if (e.s2) begin waitclk(bitp); s2 = txd; end
            chk_eq("R3 frame data", int'(bits), int'(e.d));
            chk_eq("R3 start/stop levels", int'({st, s1, s2}), 3);
            if (e.pe) chk_eq("R4 tx parity bit", int'(pb), int'(exp_par(e.d, e.nb, e.odd)));
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog (R1..R12 run): actual cycles=%0d expected fewer", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [8:0] s;
      int t0, t1, lows;
      waitclk(3);
      rst_n = 1'b1;
      waitclk(2);
      // R1 reset state
      reg_read(2'd3, s);
      chk_eq("R1 status after reset", int'(s), 3);
      chk_eq("R1 txd/rts_n/tx_irq/rx_irq", int'({txd, rts_n, tx_irq, rx_irq}), 4'b1010);

      // R5 / R6 double buffering and complete flag
      configure(1, 0, 0, 0, 0, 0, 0, 3);
      send_tx(9'h03C);
      waitclk(4);
      reg_read(2'd3, s);
      chk_eq("R5 buffer moved to shifter", int'(s[0]), 1);
      chk_eq("R6 complete low while shifting", int'(s[1]), 0);
      send_tx(9'h0C3);
      reg_read(2'd3, s);
      chk_eq("R5 buffer full after second write", int'(s[0]), 0);
      chk_eq("R6 tx_irq follows empty flag", int'(tx_irq), 0);
      wait_tx_idle();
      reg_read(2'd3, s);
      chk_eq("R6 complete after last frame", int'(s[1:0]), 3);

      // R6 tx_irq on completion source
      configure(1, 0, 0, 0, 0, 1, 0, 3);
      send_tx(9'h081);
      waitclk(4);
      chk_eq("R6 tx_irq low while shifting (complete source)", int'(tx_irq), 0);
      wait_tx_idle();
      chk_eq("R6 tx_irq high when done (complete source)", int'(tx_irq), 1);

      // R3 / R4 formats
      configure(0, 1, 1, 1, 0, 0, 0, 3);
      send_tx(9'h055);
      wait_tx_idle();
      configure(2, 1, 0, 0, 0, 0, 0, 3);
      send_tx(9'h1A3);
      wait_tx_idle();

      // R11 clear-to-send gating
      configure(1, 0, 0, 0, 0, 0, 1, 3);
      cts_n = 1'b1;
      send_tx(9'h05A);
      lows = 0;
      for (int i = 0; i < 3 * bitp; i++) begin waitclk(1); if (!txd) lows++; end
      chk_eq("R11 no start while cts_n high", lows, 0);
      reg_read(2'd3, s);
      chk_eq("R11 character still pending", int'(s[0]), 0);
      cts_n = 1'b0;
      wait_tx_idle();

      // R2 bit period for each divide code
      for (int k = 0; k < 4; k++) begin
         int ps, nn;
         ps = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : 3;
         nn = (k == 0) ? 5 : (k == 2) ? 1 : 0;
         configure(1, 0, 0, 0, ps, 0, 0, nn);
         send_tx(9'h055);
         @(posedge txd); t0 = cyc;
         @(negedge txd); t1 = cyc;
         chk_eq("R2 bit period in clocks", t1 - t0, bitp);
         wait_tx_idle();
      end

      // R7 / R12 receive path
      configure(1, 0, 0, 0, 0, 0, 0, 3);
      waitclk(bitp);
      send_rx(9'h0A5, 0, 0);
      reg_read(2'd3, s);
      chk_eq("R7 receive-full, no errors", int'(s[5:2]), 1);
      chk_eq("R12 rts_n high when full / R7 rx_irq", int'({rts_n, rx_irq}), 3);
      reg_read(2'd0, s);
      chk_eq("R7 received character", int'(s), 'hA5);
      reg_read(2'd3, s);
      chk_eq("R7 read clears receive-full", int'(s[2]), 0);
      chk_eq("R12 rts_n low when empty", int'(rts_n), 0);

      // R8 short low pulse rejected
      rxd = 1'b0; waitclk(bitp / 4); rxd = 1'b1;
      waitclk(12 * bitp);
      reg_read(2'd3, s);
      chk_eq("R8 glitch gives no character", int'(s[2]), 0);
      send_rx(9'h03C, 0, 0);
      reg_read(2'd0, s);
      chk_eq("R8 receiver still works after glitch", int'(s), 'h3C);

      // R9 overrun
      send_rx(9'h011, 0, 0);
      send_rx(9'h022, 0, 0);
      reg_read(2'd3, s);
      chk_eq("R9 full and overrun", int'(s[3:2]), 3);
      reg_read(2'd0, s);
      chk_eq("R9 old character kept", int'(s), 'h11);
      reg_read(2'd3, s);
      chk_eq("R9 read clears overrun", int'(s[3:2]), 0);

      // R10 parity and framing errors, R4 on receive
      configure(0, 1, 0, 0, 0, 0, 0, 3);
      send_rx(9'h02B, 1, 0);
      reg_read(2'd3, s);
      chk_eq("R10 parity error flagged", int'(s[5:4]), 1);
      reg_read(2'd0, s);
      chk_eq("R10 character with bad parity", int'(s), 'h2B);
      send_rx(9'h02B, 0, 0);
      reg_read(2'd3, s);
      chk_eq("R4 even parity accepted", int'(s[5:4]), 0);
      reg_read(2'd0, s);
      send_rx(9'h044, 0, 1);
      reg_read(2'd3, s);
      chk_eq("R10 framing error flagged", int'(s[5:4]), 2);
      reg_read(2'd0, s);
      chk_eq("R10 character with bad stop", int'(s), 'h44);
      configure(2, 1, 1, 1, 0, 0, 0, 3);
      waitclk(bitp);
      send_rx(9'h1C6, 0, 0);
      reg_read(2'd3, s);
      chk_eq("R4 odd parity 9-bit accepted", int'(s[5:2]), 1);
      reg_read(2'd0, s);
      chk_eq("R7 9-bit character", int'(s), 'h1C6);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule